// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory that takes one command on every enabled clock edge and loses no cycle when a read follows a write or a write follows a read. Address, command and byte selects are captured on the rising edge. A write's data comes onto the input bus two enabled edges after its command. A read's data leaves through an output register and can be sampled on the second enabled edge after the command. Because both kinds of data use the same slot, reads and writes can be interleaved freely.

Write commands wait in a two-stage address pipeline until their data arrives. A read that follows a write to the same word must still see that write, so each read is merged with any write that is still waiting. The merge is done lane by lane, and the newest write takes priority. A small sequencer can step the two low address bits through a four-beat burst, in either counting order or XOR order, and it repeats the command type of the last load. The data bus is modelled as a separate input, output and output-enable. The output-enable drops by itself while write data is on the bus, and an asynchronous output-disable pin can also force it low.

Top module: `zs_sram`

## Requirements
- R1: A read captured at enabled edge k has its word on `dout` with `dout_oe` high from enabled edge k+1 until the next enabled edge, so it is sampled at edge k+2.
- R2: For a write captured at enabled edge k, `din` is sampled at enabled edge k+2 and stored at that write's address.
- R3: While `cke` is low, no command is taken, nothing is written to the array, and every register holds, including `dout` and the output-valid state.
- R4: Any mix of reads and writes can be issued on consecutive enabled edges with no idle cycle between them.
- R5: Byte lane i is bits [9i+8:9i] of the word. A write changes lane i only when `be_n[i]` is low. All other lanes keep their contents.
- R6: A load cycle issues a command only when `cs1_n` is low, `cs2` is high and `cs3_n` is low. Otherwise it is a no-operation: nothing is written and the output is not driven.
- R7: `dout_oe` is low in the cycle where a write's data is on the bus, that is, after edge k+1 for a write captured at edge k.
- R8: While `oe_n` is high, `dout_oe` is low at once, without waiting for a clock edge.
- R9: A read returns the newest data for its address. Lanes of writes issued earlier but not yet stored are merged over the array contents. If two pending writes hit the same word, the later one wins on the lanes they share.
- R10: With `adv_ld` high, the command type of the last load repeats. Its address keeps the upper bits of the loaded address, and its low two bits are (start + n) mod 4 when `burst_ilv` is low, or start XOR n when `burst_ilv` is high. Here n (mod 4) is the number of advances since the load. Chip enables, `we_n` and `addr` are ignored on advance cycles.
- R11: Advances that follow a deselected load are also no-operations.
- R12: While reset is asserted and after it, the pipeline holds no-operations, `dout_oe` is low and `dout` is zero. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, active high |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 = load a new command, 1 = advance the burst |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| be_n | input | NL | Per-lane write select, active low |
| burst_ilv | input | 1 | 0 = counting burst order, 1 = XOR burst order |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output disable, active high |
| din | input | NL*LW | Write data, due two enabled edges after its command |
| dout | output | NL*LW | Read data from the output register |
| dout_oe | output | 1 | Output driver enable |

## Verification
Each result falls at a fixed count of enabled edges from its command. Read data and the driver state are due after the first enabled edge and are held until the second. Write data is consumed at the second enabled edge. The bench keeps a table of expected output and input data indexed by enabled-cycle number. It fills slot t+2 when it issues the command in slot t, and it compares the outputs one nanosecond after each falling edge. Stalled cycles do not advance the slot number, so during a stall the outputs are compared against the same slot. Lane merging and burst addresses are computed in the bench's own reference model in command order.

// File: rtl/zs_sram_pkg.sv
`timescale 1ns/1ps
package zs_sram_pkg;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  // low two address bits of burst beat 'beat' from 'start'
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zs_merge.sv
`timescale 1ns/1ps
module zs_merge #(
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic [NL*LW-1:0] base,
  input  logic [NL*LW-1:0] upd,
  input  logic [NL-1:0]    pick,
  output logic [NL*LW-1:0] merged
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign merged[g*LW +: LW] = pick[g] ? upd[g*LW +: LW] : base[g*LW +: LW];
  end
endmodule

// File: rtl/zs_seq.sv
`timescale 1ns/1ps
module zs_seq import zs_sram_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          adv_ld,
  input  logic          sel_ok,
  input  logic          wr_req,
  input  logic          ilv,
  input  logic [AW-1:0] addr_in,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    nxt_cnt;
  op_e           op_q;

  assign nxt_cnt = cnt_q + 2'd1;

  always_comb begin
    if (!adv_ld) begin
      cmd_op   = sel_ok ? (wr_req ? OP_WR : OP_RD) : OP_NOP;
      cmd_addr = addr_in;
    end else begin
      cmd_op   = op_q;
      cmd_addr = {base_q[AW-1:2], burst_lo(base_q[1:0], nxt_cnt, ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      op_q   <= OP_NOP;
    end else if (cke) begin
      if (!adv_ld) begin
        base_q <= addr_in;
        cnt_q  <= 2'd0;
      end else begin
        cnt_q  <= nxt_cnt;
      end
      op_q <= cmd_op;
    end
  end
endmodule

// File: rtl/zs_wpipe.sv
`timescale 1ns/1ps
module zs_wpipe import zs_sram_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  op_e           cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [NL-1:0] cmd_lanes,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output op_e           s2_op,
  output logic [AW-1:0] s2_addr,
  output logic [NL-1:0] s2_lanes
);
  logic [NL-1:0] s1_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_NOP;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_op    <= OP_NOP;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (cke) begin
      s1_op    <= cmd_op;
      s1_addr  <= cmd_addr;
      s1_lanes <= cmd_lanes;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end
endmodule

// File: rtl/zs_array.sv
`timescale 1ns/1ps
module zs_array import zs_sram_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             cke,
  input  op_e              cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NL-1:0]    s2_lanes,
  input  logic [NL*LW-1:0] wdata,
  output logic [NL*LW-1:0] rd_q,
  output logic             wr_commit
);
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_raw;
  logic [DW-1:0] rd_fwd;
  logic          fwd_hit;

  assign wr_commit = cke && (s2_op == OP_WR);
  assign rd_raw    = mem[cmd_addr];
  // the write stored at this same edge is not yet visible in rd_raw
  assign fwd_hit   = (s2_op == OP_WR) && (s2_addr == cmd_addr);

  zs_merge #(.NL(NL), .LW(LW)) u_fwd (
    .base   (rd_raw),
    .upd    (wdata),
    .pick   (fwd_hit ? s2_lanes : '0),
    .merged (rd_fwd)
  );

  always_ff @(posedge clk) begin
    if (wr_commit) begin
      for (int i = 0; i < NL; i++) begin
        if (s2_lanes[i]) mem[s2_addr][i*LW +: LW] <= wdata[i*LW +: LW];
      end
    end
    if (cke && (cmd_op == OP_RD)) rd_q <= rd_fwd;
  end
endmodule

// File: rtl/zs_outreg.sv
`timescale 1ns/1ps
module zs_outreg import zs_sram_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  logic [NL*LW-1:0] rd_q,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [NL-1:0]    s2_lanes,
  input  logic [NL*LW-1:0] wdata,
  output logic [NL*LW-1:0] dout_q,
  output logic             out_vld
);
  localparam int DW = NL * LW;

  logic          hit;
  logic [DW-1:0] fwd;

  // second coherency point: the write storing now, one command older than the read
  assign hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

  zs_merge #(.NL(NL), .LW(LW)) u_fwd (
    .base   (rd_q),
    .upd    (wdata),
    .pick   (hit ? s2_lanes : '0),
    .merged (fwd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      out_vld <= 1'b0;
    end else if (cke) begin
      out_vld <= (s1_op == OP_RD);
      if (s1_op == OP_RD) dout_q <= fwd;
    end
  end
endmodule

// File: rtl/zs_sram.sv
`timescale 1ns/1ps
module zs_sram import zs_sram_pkg::*; #(
  parameter int AW = 6,
  parameter int NL = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             adv_ld,
  input  logic             we_n,
  input  logic [NL-1:0]    be_n,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic [NL*LW-1:0] din,
  output logic [NL*LW-1:0] dout,
  output logic             dout_oe
);
  localparam int DW = NL * LW;

  op_e           cmd_op;
  logic [AW-1:0] cmd_addr;
  op_e           s1_op, s2_op;
  logic [AW-1:0] s1_addr, s2_addr;
  logic [NL-1:0] s2_lanes;
  logic [DW-1:0] rd_q;

  // named events for the checker
  logic cs_ok, cmd_rd, cmd_wr, s1_vld, wr_commit, out_vld;

  assign cs_ok  = ~cs1_n & cs2 & ~cs3_n;
  assign cmd_rd = (cmd_op == OP_RD);
  assign cmd_wr = (cmd_op == OP_WR);
  assign s1_vld = (s1_op != OP_NOP);

  zs_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .adv_ld   (adv_ld),
    .sel_ok   (cs_ok),
    .wr_req   (~we_n),
    .ilv      (burst_ilv),
    .addr_in  (addr),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr)
  );

  zs_wpipe #(.AW(AW), .NL(NL)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_lanes (~be_n),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .s2_lanes  (s2_lanes)
  );

  zs_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
    .clk       (clk),
    .cke       (cke),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .s2_lanes  (s2_lanes),
    .wdata     (din),
    .rd_q      (rd_q),
    .wr_commit (wr_commit)
  );

  zs_outreg #(.AW(AW), .NL(NL), .LW(LW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .rd_q     (rd_q),
    .s2_op    (s2_op),
    .s2_addr  (s2_addr),
    .s2_lanes (s2_lanes),
    .wdata    (din),
    .dout_q   (dout),
    .out_vld  (out_vld)
  );

  assign dout_oe = out_vld & ~oe_n;
endmodule

// File: rtl/zs_sram_chk.sv
`timescale 1ns/1ps
module zs_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke,
  input logic          adv_ld,
  input logic          oe_n,
  input logic          cs_ok,
  input logic          cmd_rd,
  input logic          cmd_wr,
  input logic          s1_vld,
  input logic          wr_commit,
  input logic          out_vld,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);
  // R1
  rd_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd_rd) ##1 cke |=> out_vld);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(dout) && $stable(out_vld));

  // R3
  stall_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !wr_commit);

  // R7
  wr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cmd_wr) ##1 cke |=> !dout_oe);

  // R8
  oe_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);

  // R6
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !adv_ld && !cs_ok) |=> !s1_vld);

  // R11
  desel_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !adv_ld && !cs_ok) ##1 (cke && adv_ld) |=> !s1_vld);

  // R12
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!dout_oe && !out_vld) else $error("driver on in reset");
    end
  end
endmodule

bind zs_sram zs_sram_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke       (cke),
  .adv_ld    (adv_ld),
  .oe_n      (oe_n),
  .cs_ok     (cs_ok),
  .cmd_rd    (cmd_rd),
  .cmd_wr    (cmd_wr),
  .s1_vld    (s1_vld),
  .wr_commit (wr_commit),
  .out_vld   (out_vld),
  .dout      (dout),
  .dout_oe   (dout_oe)
);

// File: tb/zs_sram_tb.sv
`timescale 1ns/1ps
module zs_sram_tb;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int SLOTS = 512;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke, cs1_n, cs2, cs3_n, adv_ld, we_n, burst_ilv, oe_n;
  logic [NL-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;
  int t = 0;

  logic [DW-1:0] mem_ref [1 << AW];
  bit            exp_rd  [SLOTS];
  logic [DW-1:0] exp_d   [SLOTS];
  logic [DW-1:0] wd      [SLOTS];

  logic [AW-1:0] bm_base;
  logic [1:0]    bm_cnt;
  logic          bm_vld, bm_wr;

  always #2.5 clk = ~clk;

  zs_sram #(.AW(AW), .NL(NL), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv_ld(adv_ld), .we_n(we_n), .be_n(be_n), .burst_ilv(burst_ilv), .addr(addr),
    .oe_n(oe_n), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                             input logic [NL-1:0] ben);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NL; i++) if (!ben[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s slot %0d: actual %h expected %h", tag, what, t, act, exp);
    end
  endtask

  task automatic look(input logic oen, input string tag);
    logic eo;
    eo = exp_rd[t] & ~oen;
    chk(dout_oe === eo, tag, "dout_oe", {{(DW-1){1'b0}}, dout_oe}, {{(DW-1){1'b0}}, eo});
    if (eo) chk(dout === exp_d[t], tag, "dout", dout, exp_d[t]);
  endtask

  // one enabled cycle; entered and left just after a falling edge
  task automatic step(input logic adv, input logic [AW-1:0] a, input logic wr,
                      input logic [NL-1:0] ben, input logic [2:0] cs, input logic ilv,
                      input logic [DW-1:0] wdat, input logic oen, input string tag);
    logic v, w;
    logic [AW-1:0] ea;
    cke = 1'b1; adv_ld = adv; addr = a; we_n = ~wr; be_n = ben;
    cs1_n = ~cs[0]; cs2 = cs[1]; cs3_n = ~cs[2]; burst_ilv = ilv; oe_n = oen; din = wd[t];
    #1 look(oen, tag);
    if (!adv) begin
      v = &cs; w = wr; ea = a;
      bm_base = a; bm_cnt = 2'd0; bm_vld = v; bm_wr = w;
    end else begin
      bm_cnt = bm_cnt + 2'd1; v = bm_vld; w = bm_wr;
      ea = {bm_base[AW-1:2], ilv ? (bm_base[1:0] ^ bm_cnt) : (bm_base[1:0] + bm_cnt)};
    end
    if (v && w) begin
      wd[t+2] = wdat;
      mem_ref[ea] = lane_mix(mem_ref[ea], wdat, ben);
    end
    if (v && !w) begin
      exp_rd[t+2] = 1'b1;
      exp_d[t+2]  = mem_ref[ea];
    end
    t++;
    @(negedge clk);
  endtask

  task automatic wr_c(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] ben,
                      input string tag);
    step(1'b0, a, 1'b1, ben, 3'b111, 1'b0, d, 1'b0, tag);
  endtask

  task automatic rd_c(input logic [AW-1:0] a, input string tag);
    step(1'b0, a, 1'b0, 4'hF, 3'b111, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic nop(input logic oen, input string tag);
    step(1'b0, '0, 1'b0, 4'hF, 3'b000, 1'b0, '0, oen, tag);
  endtask

  // advance: address, write enable and chip enables are deliberately junk
  task automatic adv_c(input logic ilv, input logic [DW-1:0] d, input string tag);
    step(1'b1, 6'h3F, 1'b0, 4'h0, 3'b000, ilv, d, 1'b0, tag);
  endtask

  task automatic stall(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      cke = 1'b0; adv_ld = 1'b0; addr = 6'd12; we_n = 1'b0; be_n = '0;
      cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; oe_n = 1'b0; din = wd[t];
      #1 look(1'b0, tag);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke = 1'b1; adv_ld = 1'b0; addr = '0; we_n = 1'b1; be_n = '1;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; burst_ilv = 1'b0; oe_n = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk(dout_oe === 1'b0, "R12", "dout_oe in reset", {{(DW-1){1'b0}}, dout_oe}, '0);
    chk(dout === '0, "R12", "dout in reset", dout, '0);
    rst_n = 1'b1;
    nop(1'b0, "R12");
    nop(1'b0, "R12");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr_c(AW'(i), 36'hA00000000 | DW'(i * 7 + 3), 4'h0, "R2");
    for (int i = 0; i < 16; i++) rd_c(AW'(i), "R1");
    nop(1'b0, "R1"); nop(1'b0, "R1");
  endtask

  task automatic t_alt();
    wr_c(6'd8, 36'h111111111, 4'h0, "R4");
    rd_c(6'd8, "R9");
    wr_c(6'd9, 36'h222222222, 4'h0, "R4");
    rd_c(6'd8, "R4");
    rd_c(6'd9, "R9");
    wr_c(6'd8, 36'h333333333, 4'h0, "R4");
    nop(1'b0, "R4");
    rd_c(6'd8, "R9");
    wr_c(6'd9, 36'h444444444, 4'h0, "R4");
    nop(1'b0, "R4"); nop(1'b0, "R4");
    rd_c(6'd9, "R4");
    nop(1'b0, "R4"); nop(1'b0, "R4");
  endtask

  task automatic t_bytes();
    wr_c(6'd10, 36'hF0F0F0F0F, 4'h0, "R5");
    wr_c(6'd10, 36'h123456789, 4'b1010, "R5");
    rd_c(6'd10, "R5");
    wr_c(6'd10, 36'hABCDEF012, 4'b1100, "R9");
    wr_c(6'd10, 36'h555AAA555, 4'b1001, "R9");
    rd_c(6'd10, "R9");
    wr_c(6'd10, 36'hFFFFFFFFF, 4'hF, "R5");
    nop(1'b0, "R5");
    rd_c(6'd10, "R5");
    nop(1'b0, "R5"); nop(1'b0, "R5");
  endtask

  task automatic t_cs();
    wr_c(6'd11, 36'h0CAFE0CAF, 4'h0, "R6");
    step(1'b0, 6'd11, 1'b1, 4'h0, 3'b110, 1'b0, 36'h999999991, 1'b0, "R6");
    step(1'b0, 6'd11, 1'b1, 4'h0, 3'b101, 1'b0, 36'h999999992, 1'b0, "R6");
    step(1'b0, 6'd11, 1'b1, 4'h0, 3'b011, 1'b0, 36'h999999993, 1'b0, "R6");
    rd_c(6'd11, "R6");
    step(1'b0, 6'd11, 1'b0, 4'hF, 3'b101, 1'b0, '0, 1'b0, "R6");
    nop(1'b0, "R6"); nop(1'b0, "R6"); nop(1'b0, "R6");
  endtask

  task automatic t_stall();
    wr_c(6'd12, 36'h00000C0DE, 4'h0, "R3");
    stall(1, "R3");
    wr_c(6'd13, 36'h0000BEEF1, 4'h0, "R3");
    stall(2, "R3");
    rd_c(6'd12, "R3");
    stall(1, "R3");
    rd_c(6'd13, "R3");
    stall(1, "R3");
    nop(1'b0, "R3");
    stall(2, "R3");
    nop(1'b0, "R3");
    rd_c(6'd12, "R3");
    nop(1'b0, "R3"); nop(1'b0, "R3");
  endtask

  task automatic t_oe();
    wr_c(6'd14, 36'h7E7E7E7E7, 4'h0, "R8");
    rd_c(6'd14, "R8");
    nop(1'b0, "R8");
    nop(1'b1, "R8");
    rd_c(6'd14, "R8");
    nop(1'b0, "R8");
    nop(1'b0, "R8");
    rd_c(6'd1, "R7");
    wr_c(6'd2, 36'h2468ACE02, 4'h0, "R7");
    rd_c(6'd3, "R7");
    nop(1'b0, "R7");
    nop(1'b0, "R7");
    rd_c(6'd2, "R7");
    nop(1'b0, "R7"); nop(1'b0, "R7");
  endtask

  task automatic t_burst();
    wr_c(6'h1A, 36'h1A1A1A1A0, 4'h0, "R10");
    adv_c(1'b0, 36'h1A1A1A1A1, "R10");
    adv_c(1'b0, 36'h1A1A1A1A2, "R10");
    adv_c(1'b0, 36'h1A1A1A1A3, "R10");
    rd_c(6'h19, "R10");
    for (int k = 0; k < 4; k++) adv_c(1'b0, '0, "R10");
    rd_c(6'h19, "R10");
    for (int k = 0; k < 3; k++) adv_c(1'b1, '0, "R10");
    step(1'b0, 6'h1E, 1'b1, 4'h0, 3'b111, 1'b1, 36'h0E0E0E0E0, 1'b0, "R10");
    adv_c(1'b1, 36'h0E0E0E0E1, "R10");
    adv_c(1'b1, 36'h0E0E0E0E2, "R10");
    adv_c(1'b1, 36'h0E0E0E0E3, "R10");
    rd_c(6'h1C, "R10");
    for (int k = 0; k < 3; k++) adv_c(1'b0, '0, "R10");
    nop(1'b0, "R10"); nop(1'b0, "R10");
  endtask

  task automatic t_desel_burst();
    step(1'b0, 6'h1A, 1'b1, 4'h0, 3'b101, 1'b0, 36'hDEADDEAD0, 1'b0, "R11");
    adv_c(1'b0, 36'hDEADDEAD1, "R11");
    adv_c(1'b0, 36'hDEADDEAD2, "R11");
    step(1'b0, 6'h1A, 1'b0, 4'hF, 3'b011, 1'b0, '0, 1'b0, "R11");
    adv_c(1'b0, '0, "R11");
    adv_c(1'b0, '0, "R11");
    rd_c(6'h1A, "R11");
    rd_c(6'h1B, "R11");
    rd_c(6'h18, "R11");
    nop(1'b0, "R11"); nop(1'b0, "R11");
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      exp_rd[i] = 1'b0;
      exp_d[i]  = '0;
      wd[i]     = 36'h5A5A5A5A5 ^ DW'(i);
    end
    for (int i = 0; i < (1 << AW); i++) mem_ref[i] = 'x;
    bm_base = '0; bm_cnt = 2'd0; bm_vld = 1'b0; bm_wr = 1'b0;
    @(negedge clk);
    t_reset();
    t_fill();
    t_alt();
    t_bytes();
    t_cs();
    t_stall();
    t_oe();
    t_burst();
    t_desel_burst();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule